// File: doc/BRIEF.md
# Port Wake Status and Interrupt Register

This block keeps one control register that records remote-wake activity for two families of ports: high-speed-capable USB2 ports and SuperSpeed ports. Each port owns a sticky wake-event status bit and a wake-interrupt enable bit. A one-cycle wake pulse from the port's detector sets the event bit, and the bit stays set until software clears it. A port is flagged as having a pending remote wake only while both of its bits are set. One interrupt line combines the flags of all ports.

The event bits are write-one-to-clear. The enable bits are plain read-write bits in the same word. So every write has to carry zeros in the event positions of the ports it does not mean to clear. To arm a port, software first writes a one to that port's event bit to drop stale history. In a later write it sets the enable. To disarm a port, it first drops the enable and then writes a one to the event bit to discard anything still pending.

Top module: `wake_evt_reg`

## Requirements
- R1: After reset every event bit and every enable bit reads 0. Both per-port flag vectors and the interrupt output are 0.
- R2: Register layout, with H USB2 ports and S SuperSpeed ports (defaults 4 and 4, giving a 16-bit word). USB2 event bits sit at [H-1:0] and SuperSpeed event bits at [H+S-1:H]. USB2 enable bits sit at [2H+S-1:H+S] and SuperSpeed enable bits at [2H+2S-1:2H+S]. Port k of a group uses bit k of that group's field.
- R3: A wake pulse on a port sets that port's event bit at the next clock edge. The bit then stays 1 after the pulse ends.
- R4: On a write, an event position carrying 1 clears that event bit. An event position carrying 0 leaves the bit unchanged. With no write and no pulse, the event bits hold.
- R5: If a wake pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R6: On a write, every enable bit takes the value written to its position. Between writes the enable bits hold.
- R7: A port's remote-wake flag is 1 exactly when both its enable bit and its event bit are 1.
- R8: The interrupt output is 1 exactly when at least one port of either group has its remote-wake flag set.
- R9: In the arming order (clear the event, then set the enable in a later write), a stale event from before the clear raises no flag. A new wake pulse after arming raises the flag. In the disarming order (clear the enable, then clear the event), the flag drops at the first write and the event bit drops at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2*(N_HS+N_SS) | Write word: event positions are write-one-to-clear, enable positions are loaded |
| rd_data | output | 2*(N_HS+N_SS) | Current register contents |
| hs_wake_pulse | input | N_HS | Wake pulses from the USB2 port detectors |
| ss_wake_pulse | input | N_SS | Wake pulses from the SuperSpeed port detectors |
| hs_remote_wake | output | N_HS | Per-port remote-wake flags, USB2 group |
| ss_remote_wake | output | N_SS | Per-port remote-wake flags, SuperSpeed group |
| wake_irq | output | 1 | Combined wake interrupt |

## Verification
The bench builds the block with its defaults, four USB2 ports and four SuperSpeed ports. This fills all sixteen register positions, so every field boundary of the layout is reached. The two groups have the same width, so a swapped offset between them shows up only as misplaced bits, and the directed cases are chosen to expose that. Random writes carry sparse event masks and random enables, mixed with random pulses. This hits the set-wins collision on single bits and clears of ports that are not pending, and it checks the arming and disarming orders directly.

// File: rtl/wake_reg_pkg.sv
package wake_reg_pkg;

    typedef enum logic {
        GRP_HS = 1'b0,
        GRP_SS = 1'b1
    } port_grp_e;

    // Lowest bit of a group's event field.
    function automatic int unsigned evt_lsb(port_grp_e grp, int unsigned n_hs);
        return (grp == GRP_HS) ? 0 : n_hs;
    endfunction

    // Lowest bit of a group's enable field; enables follow all event bits.
    function automatic int unsigned ie_lsb(port_grp_e grp, int unsigned n_hs,
                                           int unsigned n_ss);
        return (grp == GRP_HS) ? (n_hs + n_ss) : (2 * n_hs + n_ss);
    endfunction

endpackage

// File: rtl/wake_port_group.sv
module wake_port_group #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_evt,
    input  logic [N-1:0] wr_ie,
    input  logic [N-1:0] pulse,
    output logic [N-1:0] evt_o,
    output logic [N-1:0] ie_o,
    output logic [N-1:0] remote_o,
    output logic         any_o
);

    typedef struct packed {
        logic [N-1:0] evt;
        logic [N-1:0] ie;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [N-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = wr_en ? wr_evt : '0;
        // A pulse in the same cycle as a clear leaves the bit set.
        st_d.evt = (st_q.evt & ~clr_mask) | pulse;
        if (wr_en) begin
            st_d.ie = wr_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < N; p++) begin : g_port
        assign remote_o[p] = st_q.evt[p] & st_q.ie[p];
    end

    assign evt_o = st_q.evt;
    assign ie_o  = st_q.ie;
    assign any_o = |remote_o;

endmodule

// File: rtl/wake_evt_reg.sv
module wake_evt_reg
    import wake_reg_pkg::*;
#(
    parameter  int unsigned N_HS  = 4,
    parameter  int unsigned N_SS  = 4,
    localparam int unsigned REG_W = 2 * (N_HS + N_SS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_HS-1:0]  hs_wake_pulse,
    input  logic [N_SS-1:0]  ss_wake_pulse,
    output logic [N_HS-1:0]  hs_remote_wake,
    output logic [N_SS-1:0]  ss_remote_wake,
    output logic             wake_irq
);

    localparam int unsigned HS_EVT = evt_lsb(GRP_HS, N_HS);
    localparam int unsigned SS_EVT = evt_lsb(GRP_SS, N_HS);
    localparam int unsigned HS_IE  = ie_lsb(GRP_HS, N_HS, N_SS);
    localparam int unsigned SS_IE  = ie_lsb(GRP_SS, N_HS, N_SS);

    logic [N_HS-1:0] hs_evt, hs_ie;
    logic [N_SS-1:0] ss_evt, ss_ie;
    logic            hs_any, ss_any;

    wake_port_group #(.N(N_HS)) i_hs_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_evt   (wr_data[HS_EVT +: N_HS]),
        .wr_ie    (wr_data[HS_IE +: N_HS]),
        .pulse    (hs_wake_pulse),
        .evt_o    (hs_evt),
        .ie_o     (hs_ie),
        .remote_o (hs_remote_wake),
        .any_o    (hs_any)
    );

    wake_port_group #(.N(N_SS)) i_ss_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_evt   (wr_data[SS_EVT +: N_SS]),
        .wr_ie    (wr_data[SS_IE +: N_SS]),
        .pulse    (ss_wake_pulse),
        .evt_o    (ss_evt),
        .ie_o     (ss_ie),
        .remote_o (ss_remote_wake),
        .any_o    (ss_any)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[HS_EVT +: N_HS]  = hs_evt;
        rd_data[SS_EVT +: N_SS]  = ss_evt;
        rd_data[HS_IE +: N_HS]   = hs_ie;
        rd_data[SS_IE +: N_SS]   = ss_ie;
    end

    assign wake_irq = hs_any | ss_any;

endmodule

// File: rtl/wake_evt_reg_chk.sv
module wake_evt_reg_chk #(
    parameter  int unsigned N_HS  = 4,
    parameter  int unsigned N_SS  = 4,
    localparam int unsigned REG_W = 2 * (N_HS + N_SS),
    localparam int unsigned NEVT  = N_HS + N_SS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [N_HS-1:0]  hs_wake_pulse,
    input logic [N_SS-1:0]  ss_wake_pulse,
    input logic [N_HS-1:0]  hs_remote_wake,
    input logic [N_SS-1:0]  ss_remote_wake,
    input logic             wake_irq
);

    localparam int unsigned HS_IE = NEVT;
    localparam int unsigned SS_IE = NEVT + N_HS;

    // R7
    hs_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_remote_wake == (rd_data[0 +: N_HS] & rd_data[HS_IE +: N_HS]));

    // R7
    ss_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_remote_wake == (rd_data[N_HS +: N_SS] & rd_data[SS_IE +: N_SS]));

    // R8
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq == ((|hs_remote_wake) | (|ss_remote_wake)));

    // R3
    hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_wake_pulse) |=>
        ((rd_data[0 +: N_HS] & $past(hs_wake_pulse)) == $past(hs_wake_pulse)));

    // R3
    ss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ss_wake_pulse) |=>
        ((rd_data[N_HS +: N_SS] & $past(ss_wake_pulse)) == $past(ss_wake_pulse)));

    // R6
    ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[NEVT +: NEVT] == $past(wr_data[NEVT +: NEVT])));

    // R4
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hs_wake_pulse == '0 && ss_wake_pulse == '0) |=>
        $stable(rd_data[0 +: NEVT]));

    // R4
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_data[0 +: NEVT]) && hs_wake_pulse == '0 && ss_wake_pulse == '0) |=>
        (rd_data[0 +: NEVT] == '0));

endmodule

bind wake_evt_reg wake_evt_reg_chk #(.N_HS(N_HS), .N_SS(N_SS)) i_wake_evt_reg_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .hs_wake_pulse  (hs_wake_pulse),
    .ss_wake_pulse  (ss_wake_pulse),
    .hs_remote_wake (hs_remote_wake),
    .ss_remote_wake (ss_remote_wake),
    .wake_irq       (wake_irq)
);

// File: tb/test_wake_evt_reg.sv
`timescale 1ns/1ps
module test_wake_evt_reg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [3:0]  hs_wake_pulse, ss_wake_pulse;
    logic [3:0]  hs_remote_wake, ss_remote_wake;
    logic        wake_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state (layout per R2: hs evt [3:0], ss evt [7:4], hs ie [11:8], ss ie [15:12])
    logic [3:0] m_hs_evt, m_ss_evt, m_hs_ie, m_ss_ie;

    always #2.5 clk = ~clk;

    wake_evt_reg i_wake_evt_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .hs_wake_pulse  (hs_wake_pulse),
        .ss_wake_pulse  (ss_wake_pulse),
        .hs_remote_wake (hs_remote_wake),
        .ss_remote_wake (ss_remote_wake),
        .wake_irq       (wake_irq)
    );

    function automatic logic [15:0] exp_word();
        return {m_ss_ie, m_hs_ie, m_ss_evt, m_hs_evt};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " word"}, rd_data, exp_word());
        chk({tag, " hs flags (R7)"}, {12'd0, hs_remote_wake}, {12'd0, m_hs_evt & m_hs_ie});
        chk({tag, " ss flags (R7)"}, {12'd0, ss_remote_wake}, {12'd0, m_ss_evt & m_ss_ie});
        chk({tag, " irq (R8)"}, {15'd0, wake_irq},
            {15'd0, |((m_hs_evt & m_hs_ie) | (m_ss_evt & m_ss_ie))});
    endtask

    task automatic step(bit wr, logic [15:0] d, logic [3:0] hp, logic [3:0] sp, string tag);
        @(negedge clk);
        wr_en = wr; wr_data = d; hs_wake_pulse = hp; ss_wake_pulse = sp;
        @(posedge clk);
        #1;
        m_hs_evt = (m_hs_evt & ~(wr ? d[3:0] : 4'd0)) | hp;
        m_ss_evt = (m_ss_evt & ~(wr ? d[7:4] : 4'd0)) | sp;
        if (wr) begin
            m_hs_ie = d[11:8];
            m_ss_ie = d[15:12];
        end
        wr_en = 1'b0; wr_data = '0; hs_wake_pulse = '0; ss_wake_pulse = '0;
        check_all(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        hs_wake_pulse = '0; ss_wake_pulse = '0;
        m_hs_evt = '0; m_ss_evt = '0; m_hs_ie = '0; m_ss_ie = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset");

        // R2/R3: single pulses land in their documented positions and stay
        step(0, 16'h0000, 4'b0100, 4'b0000, "R2 hs port2 evt");
        chk("R2 hs port2 at bit2", rd_data, 16'h0004);
        step(0, 16'h0000, 4'b0000, 4'b0010, "R2 ss port1 evt");
        chk("R2 ss port1 at bit5", rd_data, 16'h0024);
        step(0, 16'h0000, 4'b0000, 4'b0000, "R3 sticky");
        // R6/R7/R8: enable hs port2 only
        step(1, 16'h0400, 4'b0000, 4'b0000, "R6 enable hs2");
        chk("R7 hs2 flagged", {12'd0, hs_remote_wake}, 16'h0004);
        // R4: writing zeros to events leaves them
        step(1, 16'h0400, 4'b0000, 4'b0000, "R4 write zero evt");
        step(1, 16'h0404, 4'b0000, 4'b0000, "R4 clear hs2");
        chk("R8 irq low after clear", {15'd0, wake_irq}, 16'h0000);
        // R5: collision on ss port1, set wins
        step(1, 16'h2020, 4'b0000, 4'b0010, "R5 set wins");
        chk("R5 ss1 still set", {15'd0, rd_data[5]}, 16'h0001);
        chk("R8 irq from ss1", {15'd0, wake_irq}, 16'h0001);
        step(1, 16'h0020, 4'b0000, 4'b0000, "R4 clear ss1");

        // R9: arming order with stale event on hs port0
        step(0, 16'h0000, 4'b0001, 4'b0000, "R9 stale event");
        step(1, 16'h0001, 4'b0000, 4'b0000, "R9 clear stale");
        step(1, 16'h0100, 4'b0000, 4'b0000, "R9 arm");
        chk("R9 no flag after arm", {12'd0, hs_remote_wake}, 16'h0000);
        step(0, 16'h0000, 4'b0001, 4'b0000, "R9 new wake");
        chk("R9 flag on new wake", {12'd0, hs_remote_wake}, 16'h0001);
        step(1, 16'h0000, 4'b0000, 4'b0000, "R9 disarm enable");
        chk("R9 flag drops", {15'd0, wake_irq}, 16'h0000);
        chk("R9 event kept", {15'd0, rd_data[0]}, 16'h0001);
        step(1, 16'h0001, 4'b0000, 4'b0000, "R9 disarm clear");
        chk("R9 event cleared", rd_data, 16'h0000);

        // random mix: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 400; i++) begin
            bit         wr = ($urandom % 2) == 0;
            logic [3:0] em_h = 4'($urandom) & 4'($urandom);
            logic [3:0] em_s = 4'($urandom) & 4'($urandom);
            logic [7:0] ie   = 8'($urandom);
            logic [3:0] hp   = 4'($urandom) & 4'($urandom) & 4'($urandom);
            logic [3:0] sp   = 4'($urandom) & 4'($urandom) & 4'($urandom);
            step(wr, {ie, em_s, em_h}, hp, sp, "R3/R4/R5/R6 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule